// File: doc/BRIEF.md
# Pulse-Width Serial Bit Decoder

This block receives a single-wire serial bus that an external comparator has already turned into a logic level. It looks for the long high pulse that opens each frame and checks its length. After that it recovers the data bits one at a time. Each data bit starts with a rising transition. The bit timer restarts on that transition, so timing error from one bit never carries into the next.

The bit value comes from one of two decode modes, chosen by parameter:
- **Sampling mode** looks at the line a fixed delay after the rising transition, inside the data interval.
- **Pulse-width mode** measures the high time up to the next falling transition and compares it with a threshold.

Every timing value is a parameter. The bit period is given in nanoseconds together with the clock rate, and every interval is a percentage of that bit period. The outputs are a one-cycle strobe per decoded bit with its value, a one-cycle strobe when a frame opens and a one-cycle strobe when the line has gone quiet long enough to close the frame. Byte assembly, field parsing and error checks belong to the logic downstream.

Top module: `pwbit_decoder`

## Requirements
- R1: Every change on `bus_in` passes through a two-stage synchroniser and a three-sample majority filter. A pulse on `bus_in` that lasts a single clock produces no transition and changes no output.
- R2: The decoder may be idle when a high pulse arrives. Let L be the number of clocks between the edge that captures the rise and the edge that captures the fall. If START_MIN ≤ L ≤ START_MAX (300 % and 600 % of the bit period by default, inclusive), the pulse is accepted as the start bit. `frame_start` is then high for one cycle, 5 cycles after the edge that captures the fall.
- R3: A start candidate with L below START_MIN or above START_MAX sends the decoder back to idle with no strobe of any kind. A well-formed frame that follows still decodes.
- R4: In sampling mode (`PW_MODE`=0), each rising transition inside a frame restarts the bit timer. The line level captured SAMPLE clocks after the rise is judged (55 % of the bit period by default). `bit_valid` pulses for one cycle, SAMPLE+5 cycles after the edge that captures the rise.
- R5: Because each bit is timed from its own rise, bits whose period and high time each vary by ±10 % of nominal all decode correctly, however long the frame.
- R6: In pulse-width mode (`PW_MODE`=1), the bit is judged at the falling transition. A high length L ≥ THRESH (55 % of the bit period by default) is judged high. `bit_valid` pulses 5 cycles after the edge that captures the fall.
- R7: With `ZERO_IS_HIGH`=1, a high judgement gives `bit_value`=0 and a low judgement gives 1. With `ZERO_IS_HIGH`=0 the mapping is inverted.
- R8: Inside a frame, a timeout closes the frame when more than IDLE clocks (150 % of the bit period) pass with no new rise. The gap is measured from the edge that captured the last rise, or from the fall of the accepted start bit if no data bit followed. `frame_end` then pulses for one cycle, IDLE+5 cycles after that edge, and the decoder returns to idle ready for a new start bit.
- R9: During and after reset all three strobes are low. At most one of `bit_valid`, `frame_start` and `frame_end` is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 1 | Digitised bus level, asynchronous to clk |
| bit_valid | output | 1 | One-cycle strobe per decoded data bit |
| bit_value | output | 1 | Value of the bit flagged by bit_valid |
| frame_start | output | 1 | One-cycle strobe when a start bit is accepted |
| frame_end | output | 1 | One-cycle strobe when the post-frame gap expires |

## Verification
The bound checker enforces the following on every cycle:
- the three strobes are mutually exclusive and each lasts one cycle;
- every accepted start bit had a filtered high length inside the start window;
- every frame end was preceded by more than the idle gap since the last rise.

Only the bench scenarios can show the rest, because these properties depend on what was sent. That covers:
- that each decoded value matches the transmitted bit in both modes and both polarities;
- that ±10 % jitter never shifts a sample point into the wrong interval;
- that single-clock glitches at the sample point or in a low gap leave the bits untouched;
- that pulses just outside the start window are rejected while those exactly on its limits are accepted.

// File: rtl/pwbit_decoder.sv
module pwbit_decoder #(
  parameter int CLK_MHZ       = 250,
  parameter int BIT_NS        = 39000,
  parameter int SAMPLE_PCT    = 55,
  parameter int THRESH_PCT    = 55,
  parameter int START_MIN_PCT = 300,
  parameter int START_MAX_PCT = 600,
  parameter int IDLE_PCT      = 150,
  parameter bit PW_MODE       = 1'b0,
  parameter bit ZERO_IS_HIGH  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic bit_valid,
  output logic bit_value,
  output logic frame_start,
  output logic frame_end
);

  localparam int BIT_CYC       = CLK_MHZ * BIT_NS / 1000;
  localparam int SAMPLE_CYC    = BIT_CYC * SAMPLE_PCT / 100;
  localparam int THRESH_CYC    = BIT_CYC * THRESH_PCT / 100;
  localparam int START_MIN_CYC = BIT_CYC * START_MIN_PCT / 100;
  localparam int START_MAX_CYC = BIT_CYC * START_MAX_PCT / 100;
  localparam int IDLE_CYC      = BIT_CYC * IDLE_PCT / 100;
  localparam int CW            = $clog2(START_MAX_CYC + 2);

  localparam logic [CW-1:0] CNT_SAT   = '1;
  localparam logic [CW-1:0] K_SAMPLE  = CW'(SAMPLE_CYC - 1);
  localparam logic [CW-1:0] K_IDLE    = CW'(IDLE_CYC - 1);
  localparam logic [CW-1:0] K_SMAX    = CW'(START_MAX_CYC);
  localparam logic [CW:0]   K_LEN_MIN = (CW+1)'(START_MIN_CYC);
  localparam logic [CW:0]   K_LEN_MAX = (CW+1)'(START_MAX_CYC);
  localparam logic [CW:0]   K_THRESH  = (CW+1)'(THRESH_CYC);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA} state_t;

  logic          sync1, sync2;
  logic [2:0]    hist;
  logic          line, line_d;
  state_t        state;
  logic [CW-1:0] cnt;
  logic          armed;

  wire           maj    = (hist[0] & hist[1]) | (hist[0] & hist[2]) | (hist[1] & hist[2]);
  wire           rise   = line & ~line_d;
  wire           fall   = ~line & line_d;
  wire  [CW:0]   hlen   = {1'b0, cnt} + 1'b1;
  wire           judge  = PW_MODE ? fall : (cnt == K_SAMPLE);
  wire           hi_lvl = PW_MODE ? (hlen >= K_THRESH) : line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= 1'b0;
      sync2  <= 1'b0;
      hist   <= '0;
      line   <= 1'b0;
      line_d <= 1'b0;
    end else begin
      sync1  <= bus_in;
      sync2  <= sync1;
      hist   <= {hist[1:0], sync2};
      line   <= maj;
      line_d <= line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      armed       <= 1'b0;
      bit_valid   <= 1'b0;
      bit_value   <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      bit_valid   <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      case (state)
        S_IDLE: begin
          armed <= 1'b0;
          if (rise) begin
            state <= S_START;
            cnt   <= '0;
          end
        end
        S_START: begin
          if (fall) begin
            if (hlen >= K_LEN_MIN && hlen <= K_LEN_MAX) begin
              state       <= S_DATA;
              frame_start <= 1'b1;
              cnt         <= '0;
              armed       <= 1'b0;
            end else begin
              state <= S_IDLE;
            end
          end else if (cnt >= K_SMAX) begin
            state <= S_IDLE;
          end
        end
        S_DATA: begin
          if (rise) begin
            cnt   <= '0;
            armed <= 1'b1;
          end else if (cnt == K_IDLE) begin
            state     <= S_IDLE;
            frame_end <= 1'b1;
            armed     <= 1'b0;
          end else if (armed && judge) begin
            armed     <= 1'b0;
            bit_valid <= 1'b1;
            bit_value <= hi_lvl ^ ZERO_IS_HIGH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwbit_decoder_chk.sv
module pwbit_decoder_chk #(
  parameter int MIN_CYC  = 300,
  parameter int MAX_CYC  = 600,
  parameter int IDLE_CYC = 150
) (
  input logic clk,
  input logic rst_n,
  input logic line,
  input logic bit_valid,
  input logic frame_start,
  input logic frame_end
);

  logic ld;
  int   run, last_hi, since_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld         <= 1'b0;
      run        <= 0;
      last_hi    <= 0;
      since_rise <= 0;
    end else begin
      ld  <= line;
      run <= line ? run + 1 : 0;
      if (ld && !line) last_hi <= run;
      if (line && !ld) since_rise <= 0;
      else if (since_rise < 1000000) since_rise <= since_rise + 1;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({bit_valid, frame_start, frame_end})); // R9
  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) bit_valid |=> !bit_valid); // R9
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> !frame_start); // R2
  AST_START_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) frame_start |-> (last_hi >= MIN_CYC && last_hi <= MAX_CYC)); // R3
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> !frame_end); // R8
  AST_END_GAP: assert property (@(posedge clk) disable iff (!rst_n) frame_end |-> since_rise >= IDLE_CYC); // R8

endmodule

bind pwbit_decoder pwbit_decoder_chk #(
  .MIN_CYC(START_MIN_CYC),
  .MAX_CYC(START_MAX_CYC),
  .IDLE_CYC(IDLE_CYC)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .line(line),
  .bit_valid(bit_valid),
  .frame_start(frame_start),
  .frame_end(frame_end)
);

// File: tb/pwbit_decoder_test.sv
module pwbit_decoder_test;
  localparam int SAMPLE = 55;
  localparam int IDLE   = 150;
  localparam int LAT    = 5;

  logic clk = 1'b0, rst_n = 1'b0, bus = 1'b0;
  logic [2:0] bv, bval, fs, fe;
  int cyc = 0, tests = 0, fails = 0, strobes = 0, anchor = 0;
  string ctx = "R4";

  typedef struct {int dut; int kind; int cyc; bit val;} ev_t;
  ev_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwbit_decoder #(.BIT_NS(400), .PW_MODE(1'b0), .ZERO_IS_HIGH(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus), .bit_valid(bv[0]), .bit_value(bval[0]),
    .frame_start(fs[0]), .frame_end(fe[0]));
  pwbit_decoder #(.BIT_NS(400), .PW_MODE(1'b1), .ZERO_IS_HIGH(1'b1)) uut_pw (
    .clk(clk), .rst_n(rst_n), .bus_in(bus), .bit_valid(bv[1]), .bit_value(bval[1]),
    .frame_start(fs[1]), .frame_end(fe[1]));
  pwbit_decoder #(.BIT_NS(400), .PW_MODE(1'b0), .ZERO_IS_HIGH(1'b0)) uut_inv (
    .clk(clk), .rst_n(rst_n), .bus_in(bus), .bit_valid(bv[2]), .bit_value(bval[2]),
    .frame_start(fs[2]), .frame_end(fe[2]));

  function automatic string req_of(int d, int k);
    if (k == 0) return "R2";
    if (k == 2) return "R8";
    return (d == 0) ? "R4" : (d == 1) ? "R6" : "R7";
  endfunction

  task automatic push(int d, int k, int c, bit v);
    ev_t e;
    e.dut = d; e.kind = k; e.cyc = c; e.val = v;
    exp_q.push_back(e);
  endtask

  task automatic see(int d, int k, bit v);
    int idx = -1;
    strobes++;
    tests++;
    for (int i = 0; i < exp_q.size(); i++)
      if (idx < 0 && exp_q[i].dut == d) idx = i;
    if (idx < 0) begin
      fails++;
      $display("FAIL %s/%s dut%0d: unexpected strobe kind %0d at cycle %0d, expected none",
               req_of(d, k), ctx, d, k, cyc);
    end else begin
      if (exp_q[idx].kind != k || exp_q[idx].cyc != cyc || (k == 1 && exp_q[idx].val != v)) begin
        fails++;
        $display("FAIL %s/%s dut%0d: got kind %0d cycle %0d value %0b, expected kind %0d cycle %0d value %0b",
                 req_of(d, k), ctx, d, k, cyc, v, exp_q[idx].kind, exp_q[idx].cyc, exp_q[idx].val);
      end
      exp_q.delete(idx);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < 3; d++) begin
        if (fs[d]) see(d, 0, 1'b0);
        if (bv[d]) see(d, 1, bval[d]);
        if (fe[d]) see(d, 2, 1'b0);
      end
      for (int i = exp_q.size() - 1; i >= 0; i--)
        if (exp_q[i].cyc < cyc) begin
          tests++;
          fails++;
          $display("FAIL %s/%s dut%0d: strobe kind %0d missing, actual none, expected at cycle %0d",
                   req_of(exp_q[i].dut, exp_q[i].kind), ctx, exp_q[i].dut, exp_q[i].kind, exp_q[i].cyc);
          exp_q.delete(i);
        end
    end
  end

  task automatic hold(bit lv, int n);
    bus = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic accept_start(int hs);
    int f;
    hold(1'b1, hs);
    f = cyc + 1;
    for (int d = 0; d < 3; d++) push(d, 0, f + LAT, 1'b0);
    anchor = f;
    hold(1'b0, 15 + $urandom_range(0, 10));
  endtask

  task automatic data_bit(bit b, bit glitch);
    int per, hi, r, f;
    per = 90 + $urandom_range(0, 20);
    hi  = b ? 27 + $urandom_range(0, 6) : 68 + $urandom_range(0, 14);
    r   = cyc + 1;
    push(0, 1, r + SAMPLE + LAT, b);
    push(2, 1, r + SAMPLE + LAT, ~b);
    if (glitch) begin
      hi  = 76;
      per = 100;
      hold(1'b1, SAMPLE);
      hold(1'b0, 1);
      hold(1'b1, 20);
    end else begin
      hold(1'b1, hi);
    end
    f = cyc + 1;
    push(1, 1, f + LAT, b);
    if (glitch) begin
      hold(1'b0, 8);
      hold(1'b1, 1);
      hold(1'b0, per - hi - 9);
    end else begin
      hold(1'b0, per - hi);
    end
    anchor = r;
  endtask

  task automatic end_frame();
    for (int d = 0; d < 3; d++) push(d, 2, anchor + IDLE + LAT, 1'b0);
    hold(1'b0, 300);
  endtask

  task automatic frame(int hs, int nb, bit glitch);
    accept_start(hs);
    for (int i = 0; i < nb; i++) data_bit(glitch ? 1'b0 : 1'($urandom_range(0, 1)), glitch && (i == 1));
    end_frame();
  endtask

  task automatic reject(int hs);
    int s0;
    s0 = strobes;
    hold(1'b1, hs);
    hold(1'b0, 250);
    tests++;
    if (strobes != s0) begin
      fails++;
      $display("FAIL R3: start length %0d gave %0d strobes, expected 0", hs, strobes - s0);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    tests++;
    if ({bv, fs, fe} !== '0) begin
      fails++;
      $display("FAIL R9: outputs in reset %b, expected all zero", {bv, fs, fe});
    end
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    tests++;
    if ({bv, fs, fe} !== '0) begin
      fails++;
      $display("FAIL R9: outputs after reset %b, expected all zero", {bv, fs, fe});
    end
    ctx = "R5"; frame(450, 12, 1'b0);
    ctx = "R2"; frame(300, 6, 1'b0);
    ctx = "R2"; frame(600, 4, 1'b0);
    ctx = "R3"; reject(299);
    reject(601);
    reject(150);
    reject(800);
    ctx = "R3"; frame(420, 5, 1'b0);
    ctx = "R1"; frame(480, 3, 1'b1);
    ctx = "R8"; frame(400, 0, 1'b0);
    ctx = "R5"; frame(500, 16, 1'b0);
    ctx = "R8"; frame(440, 2, 1'b0);
    repeat (200) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8: %0d expected strobes outstanding, expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    tests++;
    fails++;
    $display("FAIL R9: watchdog expired, actual hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule